// File: doc/BRIEF.md
# Synchronous Burst Static Memory Core

This block models a clocked 32-bit static memory. It has four byte lanes and an internal two-bit burst counter. Every control input is sampled on the rising clock edge. A burst can be started by either of two load strobes. The processor-side strobe `cpu_ld_n` starts a read burst. The controller-side strobe `ctl_ld_n` starts a burst that may write on its very first cycle, and it can also restart a burst that is already running from a new address. After a load, the step input `step_n` either moves to the next word of the aligned group of four or holds the current word. Writes may occur on any cycle that continues the burst.

Write lanes come from a global write input, a byte-write input and one enable per lane. Three chip enables decide, on a load cycle only, whether the device takes part in the burst. Read data comes back on a bidirectional bus one clock after the cycle that addressed it. The bus is driven only while the output enable is LOW.

Top module: `sburst_sram`

## Requirements
- R1: A load selects the device only when `en_a_n` is LOW, `en_b_n` is LOW and `en_c` is HIGH on that edge. A load that does not meet this leaves the device idle: nothing is written, `dq` stays high-impedance, and continuation cycles do nothing until the next selecting load.
- R2: On a cycle where `cpu_ld_n` is LOW and `en_a_n` is LOW, `addr_in` is loaded and the write inputs are ignored, so memory does not change.
- R3: When `en_a_n` is HIGH, `cpu_ld_n` has no effect, and a burst in progress continues as if the strobe were HIGH.
- R4: When `ctl_ld_n` is LOW and no processor load is taken, `addr_in` is loaded even in the middle of a burst. The burst continues from that address, and a write on that same cycle goes to it.
- R5: On a continuation cycle with `step_n` LOW, the word address moves to the next one. Only the two low bits count, in linear order 0,1,2,3,0, so four steps return to the loaded word.
- R6: On a continuation cycle with `step_n` HIGH, the word address is held, and any write on that cycle goes to the held word.
- R7: `all_wr_n` LOW writes all 32 bits whatever the byte inputs are. With `all_wr_n` HIGH, `lane_wr_n` LOW and `lane_n` = 4'b0000, all 32 bits are also written.
- R8: With `all_wr_n` HIGH and `lane_wr_n` LOW, lane i (bits 8i+7..8i) is written only where `lane_n[i]` is LOW. With both `all_wr_n` and `lane_wr_n` HIGH, nothing is written.
- R9: After a cycle that accesses a word without writing it, that word's old contents drive `dq` during the next cycle, but only while `out_en_n` is LOW. After a write cycle or an idle cycle, and whenever `out_en_n` is HIGH, `dq` is high-impedance.
- R10: While `rst_n` is LOW, and afterwards until the first selecting load, the device is idle and `dq` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the burst state |
| addr_in | input | AW (6) | Word address taken on a load |
| cpu_ld_n | input | 1 | Processor-side load strobe, active LOW |
| ctl_ld_n | input | 1 | Controller-side load strobe, active LOW |
| step_n | input | 1 | LOW steps the burst counter, HIGH holds it |
| en_a_n | input | 1 | Primary chip enable, active LOW |
| en_b_n | input | 1 | Second chip enable, active LOW |
| en_c | input | 1 | Third chip enable, active HIGH |
| all_wr_n | input | 1 | Global full-word write, active LOW |
| lane_wr_n | input | 1 | Byte-write qualifier, active LOW |
| lane_n | input | 4 | Per-lane write enables, active LOW |
| out_en_n | input | 1 | Output enable for `dq`, active LOW |
| dq | inout | 32 | Bidirectional data bus |

## Verification
Each write commits at the edge where its controls are sampled. A write is therefore seen only through a later access to the same word. A read is due on `dq` during the cycle after the edge that addressed it. The bench drives inputs on the falling edge. At the next falling edge it compares `dq` against the reference model's prediction for the access made at the rising edge in between. The output enable is held over that interval, so the drive condition can be predicted as well. Cycles where the bench itself drives the bus are not compared. The effect of those writes is checked by the reads that follow them.

// File: rtl/ssb_pkg.sv
`timescale 1ns/1ps
package ssb_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  // Lane enables for one cycle from the three write inputs
  function automatic logic [LANES-1:0] lane_mask(input logic all_n,
                                                 input logic qual_n,
                                                 input logic [LANES-1:0] per_n);
    if (!all_n)       return '1;
    else if (!qual_n) return ~per_n;
    else              return '0;
  endfunction

  // Linear step of the two low address bits, wrapping in the group of four
  function automatic logic [1:0] wrap_step(input logic [1:0] lo);
    return lo + 2'd1;
  endfunction
endpackage

// File: rtl/burst_addr_ctl.sv
`timescale 1ns/1ps
module burst_addr_ctl
  import ssb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ld_n,
  input  logic          ctl_ld_n,
  input  logic          en_a_n,
  input  logic          en_b_n,
  input  logic          en_c,
  input  logic          step_n,
  input  logic [AW-1:0] addr_in,
  output logic          acc,
  output logic          cpu_cyc,
  output logic [AW-1:0] eff_addr
);
  logic          sel;
  logic          ctl_cyc;
  logic          load;
  logic          act_q;
  logic [AW-1:0] cur_q;
  logic [AW-1:0] stepped;

  assign sel      = !en_a_n && !en_b_n && en_c;
  assign cpu_cyc  = !cpu_ld_n && !en_a_n;
  assign ctl_cyc  = !ctl_ld_n && !cpu_cyc;
  assign load     = cpu_cyc || ctl_cyc;
  assign stepped  = {cur_q[AW-1:2], wrap_step(cur_q[1:0])};
  assign acc      = load ? sel : act_q;
  assign eff_addr = load ? addr_in : (step_n ? cur_q : stepped);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cur_q <= '0;
    end else begin
      if (load) act_q <= sel;
      if (load || act_q) cur_q <= eff_addr;
    end
  end

  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && act_q && !step_n) |=>
      (cur_q[1:0] == 2'($past(cur_q[1:0]) + 2'd1)) && (cur_q[AW-1:2] == $past(cur_q[AW-1:2])));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && act_q && step_n) |=> $stable(cur_q));

  // R1
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel) |=> !act_q);

  // R3
  cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_n && ctl_ld_n) |=> (act_q == $past(act_q)));
endmodule

// File: rtl/lane_decode.sv
`timescale 1ns/1ps
module lane_decode
  import ssb_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          cpu_cyc,
  input  logic          all_wr_n,
  input  logic          lane_wr_n,
  input  logic [NL-1:0] lane_n,
  output logic [NL-1:0] we
);
  logic wr_ok;
  assign wr_ok = acc && !cpu_cyc;
  assign we    = wr_ok ? lane_mask(all_wr_n, lane_wr_n, lane_n) : '0;

  // R2
  cpu_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cyc |-> (we == '0));

  // R7
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !all_wr_n) |-> (&we));
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array
  import ssb_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic [AW-1:0]      ea,
  input  logic [NL-1:0]      we,
  input  logic [NL*BYTE_W-1:0] wdata,
  output logic [NL*BYTE_W-1:0] rdata_q,
  output logic               drive_q
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_b;
    always_ff @(posedge clk) begin
      if (we[g]) mem_q[ea] <= wdata[g*BYTE_W +: BYTE_W];
      if (acc)   rd_b      <= mem_q[ea];
    end
    assign rdata_q[g*BYTE_W +: BYTE_W] = rd_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= acc && (we == '0);
  end

  // R9
  wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |=> !drive_q);

  // R9
  idle_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !drive_q);
endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram
  import ssb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr_in,
  input  logic                cpu_ld_n,
  input  logic                ctl_ld_n,
  input  logic                step_n,
  input  logic                en_a_n,
  input  logic                en_b_n,
  input  logic                en_c,
  input  logic                all_wr_n,
  input  logic                lane_wr_n,
  input  logic [LANES-1:0]    lane_n,
  input  logic                out_en_n,
  inout  wire  [DATA_W-1:0]   dq
);
  logic              acc;
  logic              cpu_cyc;
  logic [AW-1:0]     eff_addr;
  logic [LANES-1:0]  we;
  logic [DATA_W-1:0] rdata_q;
  logic              drive_q;

  burst_addr_ctl #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c), .step_n(step_n),
    .addr_in(addr_in), .acc(acc), .cpu_cyc(cpu_cyc), .eff_addr(eff_addr)
  );

  lane_decode #(.NL(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cpu_cyc(cpu_cyc),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_n(lane_n), .we(we)
  );

  sram_array #(.AW(AW), .NL(LANES)) u_mem (
    .clk(clk), .rst_n(rst_n), .acc(acc), .ea(eff_addr), .we(we),
    .wdata(dq), .rdata_q(rdata_q), .drive_q(drive_q)
  );

  assign dq = (!out_en_n && drive_q) ? rdata_q : 'z;

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !drive_q);
endmodule

// File: tb/sim_sburst_sram.sv
`timescale 1ns/1ps
module sim_sburst_sram;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic cpu_ld_n = 1, ctl_ld_n = 1, step_n = 1;
  logic en_a_n = 0, en_b_n = 0, en_c = 1;
  logic all_wr_n = 1, lane_wr_n = 1, out_en_n = 0;
  logic [3:0] lane_n = 4'hF;
  logic tb_drv = 0;
  logic [DW-1:0] tb_wd = '0;
  wire  [DW-1:0] dq;
  assign dq = tb_drv ? tb_wd : 'z;

  sburst_sram #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .cpu_ld_n(cpu_ld_n),
    .ctl_ld_n(ctl_ld_n), .step_n(step_n), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .en_c(en_c), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_n(lane_n),
    .out_en_n(out_en_n), .dq(dq)
  );

  logic [DW-1:0] bm [DEPTH];
  logic          m_act = 0;
  logic [AW-1:0] m_cur = '0;
  logic          pend_valid = 0, pend_drive = 0;
  logic [DW-1:0] pend_data = '0;
  string         pend_tag = "";
  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [3:0] ref_mask(input logic gw, input logic bwe, input logic [3:0] bw);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = !gw || (!bwe && !bw[i]);
    return m;
  endfunction

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a);
    return (a & ~AW'(3)) | ((a + AW'(1)) & AW'(3));
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h9E37_79B9 * (a + 1);
  endfunction

  task automatic cyc(input logic c_n, input logic k_n, input logic a_n, input logic b_n,
                     input logic c_hi, input logic st_n, input logic gw, input logic bwe,
                     input logic [3:0] bw, input logic oe, input logic [AW-1:0] ad,
                     input logic [DW-1:0] wd, input string tag);
    logic [DW-1:0] exp;
    logic sel, cpu, ctl, acc, intent;
    logic [AW-1:0] ea;
    logic [3:0] mk;
    @(negedge clk);
    if (pend_valid && !tb_drv) begin
      checks++;
      exp = (pend_drive && !out_en_n) ? pend_data : 'z;
      if (dq !== exp) begin
        errors++;
        $display("FAIL %s: dq=%h expected %h", pend_tag, dq, exp);
      end
    end
    intent = !gw || !bwe || (bw != 4'hF);
    cpu_ld_n = c_n; ctl_ld_n = k_n; en_a_n = a_n; en_b_n = b_n; en_c = c_hi;
    step_n = st_n; all_wr_n = gw; lane_wr_n = bwe; lane_n = bw; addr_in = ad;
    out_en_n = intent ? 1'b1 : oe; tb_drv = intent; tb_wd = wd;
    sel = !a_n && !b_n && c_hi;
    cpu = !c_n && !a_n;
    ctl = !k_n && !cpu;
    ea = m_cur; mk = '0; acc = 0;
    if (cpu) begin
      m_act = sel; m_cur = ad; ea = ad; acc = sel;
    end else if (ctl) begin
      m_act = sel; m_cur = ad; ea = ad; acc = sel;
      mk = sel ? ref_mask(gw, bwe, bw) : 4'h0;
    end else if (m_act) begin
      ea = st_n ? m_cur : ref_next(m_cur);
      m_cur = ea; acc = 1; mk = ref_mask(gw, bwe, bw);
    end
    pend_drive = acc && (mk == 4'h0);
    pend_data  = bm[ea];
    for (int i = 0; i < 4; i++) if (mk[i]) bm[ea][i*8 +: 8] = wd[i*8 +: 8];
    pend_valid = 1;
    pend_tag = tag;
  endtask

  task automatic idle(input string tag);
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, '0, '0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10: idle after reset, bus floats with output enable LOW
    idle("R10"); idle("R10"); idle("R10");
    // preload every word with a full write via controller load
    for (int a = 0; a < DEPTH; a++) cyc(1, 0, 0, 0, 1, 1, 0, 1, 4'hF, 1, AW'(a), pat(a), "R7");
    // R2: processor load with write inputs active must not write word 6
    cyc(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 1, 6, 32'hDEAD_BEEF, "R2");
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R5");   // word 7
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R5");   // wraps to 4
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R5");   // word 5
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R2");   // word 6 unchanged
    // R6/R8: held address, lanes 0 and 2 written
    cyc(1, 1, 0, 0, 1, 1, 1, 0, 4'b1010, 1, 0, 32'h1122_3344, "R8");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, "R6");
    // R4: controller load mid-burst
    cyc(1, 0, 0, 0, 1, 1, 1, 1, 4'hF, 0, 20, 0, "R4");
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R4");
    // R3: processor strobe with primary enable HIGH is ignored
    cyc(0, 1, 1, 0, 1, 0, 1, 1, 4'hF, 0, 40, 0, "R3");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, "R3");
    // R1: deselecting loads
    cyc(1, 0, 0, 0, 0, 1, 1, 1, 4'hF, 0, 30, 0, "R1");
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R1");
    cyc(1, 0, 0, 1, 1, 1, 0, 1, 4'hF, 1, 30, 32'hFFFF_0000, "R1");
    cyc(0, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, 30, 0, "R1");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, "R1");
    // R8: lane enables without qualifier write nothing
    cyc(1, 0, 0, 0, 1, 1, 1, 1, 4'h0, 1, 31, 32'h0BAD_0BAD, "R8");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, "R8");
    // R7: full word through all four lane enables
    cyc(1, 1, 0, 0, 1, 1, 1, 0, 4'h0, 1, 0, 32'hA5A5_5A5A, "R7");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, "R7");
    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic c_n, k_n, a_n, b_n, ch, st, gw, bwe, oe;
      logic [3:0] bw;
      int ws;
      string tg;
      c_n = ($urandom % 10) != 0; k_n = ($urandom % 8) != 0;
      a_n = ($urandom % 12) == 0; b_n = ($urandom % 16) == 0;
      ch  = ($urandom % 16) != 0; st  = $urandom % 2;
      ws  = $urandom % 6; gw = 1; bwe = 1; bw = 4'hF;
      if (ws == 0) gw = 0;
      else if (ws == 1) begin bwe = 0; bw = 4'($urandom); end
      else if (ws == 2) begin bwe = 0; bw = 4'h0; end
      oe = ($urandom % 5) == 0;
      if (!c_n && !a_n) tg = "R2";
      else if (!k_n) tg = "R4";
      else if (st) tg = "R6";
      else tg = "R5";
      cyc(c_n, k_n, a_n, b_n, ch, st, gw, bwe, bw, oe, AW'($urandom), $urandom, tg);
    end
    idle("R9"); idle("R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule